// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block sits between a processor that issues single-byte loads and stores and a memory that moves whole 8-byte lines. Each set holds two lines. On every access, both tags of the addressed set are compared at the same time. On a hit, the access completes from the cache alone. On a miss, a line is chosen for replacement, written back first if it has been modified, and then refilled from memory. The original access is then replayed against the refilled line.

Stores never go straight to memory. A store hit changes only the cached copy and marks the line dirty. A store miss first brings the block in and then applies the store. Replacement keeps one use bit per line. Whichever line was touched last has its use bit set, and its partner in the set has its use bit cleared.

The processor raises `cpu_req` for one cycle with the address, direction and store byte. It then waits for the one-cycle `cpu_ready` pulse, which carries the load byte on `cpu_rdata`. On the memory side, a request is held until the memory acknowledges it. Each acknowledge completes exactly one full-line transfer.

Top module: `cache_2way`

## Requirements
- R1: After reset every line is invalid, clean and has a use bit of 0, so the first access to any block misses and causes exactly one line read and no line write.
- R2: A load hit returns the addressed byte with `cpu_ready` high on the second cycle after the request cycle and causes no memory transaction.
- R3: Two blocks that map to the same set can be resident together, and accesses to either one then hit.
- R4: Referencing a line sets its use bit and clears its partner's use bit. A miss in a full set replaces the line whose use bit is 0, which is the less recently referenced one.
- R5: An invalid line is filled before any valid line is replaced, and way 0 is preferred when both lines are invalid.
- R6: A store hit writes only the cached byte and marks the line dirty. Memory is not written, and a later load returns the stored byte.
- R7: A store miss reads the block from memory and then applies the store to the cached copy. The memory copy keeps its old value until that line is evicted.
- R8: A dirty victim is written back as a whole line to the memory address formed from its own tag and set, with `mem_we`=1. This write completes before the refill read (`mem_we`=0) of the new block begins.
- R9: A clean victim is overwritten with no write transaction, so the miss costs one line read only.
- R10: `mem_req` stays high, with `mem_addr` and `mem_we` stable, until `mem_ack` is seen. Each acknowledge completes exactly one transaction, and `mem_req` is never high while `cpu_ready` is high.
- R11: `cpu_ready` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request strobe; sampled only when the block is idle |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address: tag, set index, byte offset (offset in low bits) |
| cpu_wdata | input | 8 | Store byte |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Load byte, valid while `cpu_ready` is high |
| mem_req | output | 1 | Memory line transaction request |
| mem_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr | output | ADDR_W-log2(LINE_BYTES) | Line address {tag, set} |
| mem_wline | output | LINE_BYTES*8 | Line being written back; byte k in bits [8k+7:8k] |
| mem_rline | input | LINE_BYTES*8 | Line returned by memory, same byte order |
| mem_ack | input | 1 | One-cycle acknowledge that completes the transaction |

## Verification
The cache is driven with several access patterns, and each one separates a different part of the behaviour:

- Cold reads separate the reset state from a design that hits falsely.
- Repeated reads of a resident line show that a hit touches no memory and completes in two cycles.
- A second block in the same set shows that both ways are compared and that the empty way is filled first.
- A reference order of A, B, A followed by a new block C shows whether the victim follows the use bits or a fixed way.
- A store to a resident line, followed by eviction of that line, separates write-back from write-through. It also checks the write-then-read ordering and the address of the written-back line.
- A store to a non-resident block checks allocation on a store miss.

// File: rtl/cache_pkg.sv
package cache_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CMP  = 3'd1,
        ST_WB   = 3'd2,
        ST_FILL = 3'd3,
        ST_RESP = 3'd4
    } cache_st_e;

    localparam int unsigned NUM_WAYS = 2;
endpackage

// File: rtl/cache_way_match.sv
module cache_way_match #(
    parameter int unsigned TAG_W = 7
) (
    input  logic [cache_pkg::NUM_WAYS-1:0]            vld,
    input  logic [cache_pkg::NUM_WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]                          look_tag,
    output logic [cache_pkg::NUM_WAYS-1:0]            hit
);
    for (genvar w = 0; w < cache_pkg::NUM_WAYS; w++) begin : g_cmp
        assign hit[w] = vld[w] && (tags[w] == look_tag);
    end
endmodule

// File: rtl/cache_victim_pick.sv
module cache_victim_pick (
    input  logic [1:0] vld,
    input  logic [1:0] use_b,
    output logic       victim
);
    always_comb begin
        if (!vld[0])       victim = 1'b0;
        else if (!vld[1])  victim = 1'b1;
        else if (!use_b[0]) victim = 1'b0;
        else               victim = 1'b1;
    end
endmodule

// File: rtl/cache_2way.sv
module cache_2way
    import cache_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned SETS       = 4,
    parameter int unsigned LINE_BYTES = 8
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      cpu_req,
    input  logic                                      cpu_we,
    input  logic [ADDR_W-1:0]                         cpu_addr,
    input  logic [7:0]                                cpu_wdata,
    output logic                                      cpu_ready,
    output logic [7:0]                                cpu_rdata,
    output logic                                      mem_req,
    output logic                                      mem_we,
    output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]      mem_addr,
    output logic [LINE_BYTES*8-1:0]                   mem_wline,
    input  logic [LINE_BYTES*8-1:0]                   mem_rline,
    input  logic                                      mem_ack
);
    localparam int unsigned OFF_W  = $clog2(LINE_BYTES);
    localparam int unsigned IDX_W  = $clog2(SETS);
    localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int unsigned LINE_W = LINE_BYTES * 8;

    typedef struct packed {
        cache_st_e                                  st;
        logic                                       we;
        logic [ADDR_W-1:0]                          addr;
        logic [7:0]                                 wdata;
        logic [7:0]                                 rdata;
        logic                                       way;
        logic [SETS-1:0][NUM_WAYS-1:0]              vld;
        logic [SETS-1:0][NUM_WAYS-1:0]              dty;
        logic [SETS-1:0][NUM_WAYS-1:0]              use_b;
        logic [SETS-1:0][NUM_WAYS-1:0][TAG_W-1:0]   tag;
        logic [SETS-1:0][NUM_WAYS-1:0][LINE_W-1:0]  line;
    } regs_t;

    regs_t r_q, r_d;

    logic [IDX_W-1:0]    idx_q;
    logic [TAG_W-1:0]    tag_q;
    logic [OFF_W+2:0]    bit_q;
    logic [NUM_WAYS-1:0] hit_vec;
    logic                victim;
    logic                hw;

    assign idx_q = r_q.addr[OFF_W +: IDX_W];
    assign tag_q = r_q.addr[ADDR_W-1 -: TAG_W];
    assign bit_q = {r_q.addr[OFF_W-1:0], 3'b000};
    assign hw    = hit_vec[1];

    cache_way_match #(.TAG_W(TAG_W)) u_match (
        .vld      (r_q.vld[idx_q]),
        .tags     (r_q.tag[idx_q]),
        .look_tag (tag_q),
        .hit      (hit_vec)
    );

    cache_victim_pick u_vic (
        .vld    (r_q.vld[idx_q]),
        .use_b  (r_q.use_b[idx_q]),
        .victim (victim)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    r_d.addr  = cpu_addr;
                    r_d.we    = cpu_we;
                    r_d.wdata = cpu_wdata;
                    r_d.st    = ST_CMP;
                end
            end
            ST_CMP: begin
                if (|hit_vec) begin
                    if (r_q.we) begin
                        r_d.line[idx_q][hw][bit_q +: 8] = r_q.wdata;
                        r_d.dty[idx_q][hw]              = 1'b1;
                    end else begin
                        r_d.rdata = r_q.line[idx_q][hw][bit_q +: 8];
                    end
                    r_d.use_b[idx_q][hw]  = 1'b1;
                    r_d.use_b[idx_q][!hw] = 1'b0;
                    r_d.st = ST_RESP;
                end else begin
                    r_d.way = victim;
                    if (r_q.vld[idx_q][victim] && r_q.dty[idx_q][victim])
                        r_d.st = ST_WB;
                    else
                        r_d.st = ST_FILL;
                end
            end
            ST_WB: begin
                if (mem_ack) r_d.st = ST_FILL;
            end
            ST_FILL: begin
                if (mem_ack) begin
                    r_d.line[idx_q][r_q.way] = mem_rline;
                    r_d.tag[idx_q][r_q.way]  = tag_q;
                    r_d.vld[idx_q][r_q.way]  = 1'b1;
                    r_d.dty[idx_q][r_q.way]  = 1'b0;
                    r_d.st = ST_CMP;
                end
            end
            ST_RESP: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cpu_ready = (r_q.st == ST_RESP);
    assign cpu_rdata = r_q.rdata;
    assign mem_req   = (r_q.st == ST_WB) || (r_q.st == ST_FILL);
    assign mem_we    = (r_q.st == ST_WB);
    assign mem_addr  = (r_q.st == ST_WB) ? {r_q.tag[idx_q][r_q.way], idx_q}
                                         : {tag_q, idx_q};
    assign mem_wline = r_q.line[idx_q][r_q.way];
endmodule

// File: rtl/cache_2way_chk.sv
module cache_2way_chk #(
    parameter int unsigned LA_W = 9
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cpu_ready,
    input logic            mem_req,
    input logic            mem_we,
    input logic            mem_ack,
    input logic [LA_W-1:0] mem_addr
);
    p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_no_mem_in_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_req);

    p_wb_then_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

    p_fill_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> !mem_req);
endmodule

bind cache_2way cache_2way_chk #(.LA_W(ADDR_W - $clog2(LINE_BYTES))) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_ready (cpu_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr)
);

// File: tb/sim_cache_2way.sv
module sim_cache_2way;
    localparam int CLK_T = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [11:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_ready;
    logic [7:0]  cpu_rdata;
    logic        mem_req, mem_we;
    logic [8:0]  mem_addr;
    logic [63:0] mem_wline;
    logic [63:0] mem_rline = '0;
    logic        mem_ack = 1'b0;

    logic [63:0] mem [0:511];
    int n_cmp = 0, n_bad = 0;
    int rd_n = 0, wr_n = 0;
    logic first_we;
    logic [8:0] wb_addr;
    logic [7:0] got;
    int lat;

    always #(CLK_T/2) clk = ~clk;

    cache_2way u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wline(mem_wline), .mem_rline(mem_rline),
        .mem_ack(mem_ack)
    );

    function automatic logic [7:0] pat(input logic [8:0] la, input logic [2:0] off);
        return {la[4:0], off} ^ 8'h5A;
    endfunction

    function automatic logic [11:0] mk(input logic [6:0] t, input logic [1:0] s, input logic [2:0] o);
        return {t, s, o};
    endfunction

    // memory model: each request is acknowledged once, two cycles later
    initial begin
        for (int i = 0; i < 512; i++)
            for (int b = 0; b < 8; b++) mem[i][b*8 +: 8] = pat(9'(i), 3'(b));
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req) begin
                repeat (2) @(negedge clk);
                if (rd_n + wr_n == 0) first_we = mem_we;
                if (mem_we) begin
                    mem[mem_addr] = mem_wline;
                    wb_addr = mem_addr;
                    wr_n++;
                end else begin
                    mem_rline = mem[mem_addr];
                    rd_n++;
                end
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
            end
        end
    end

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [11:0] a, input logic [7:0] wd);
        @(negedge clk);
        rd_n = 0; wr_n = 0; first_we = 1'bx;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        lat = 1;
        while (!cpu_ready && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        got = cpu_rdata;
        @(negedge clk);
        chk("R11", 64'(cpu_ready), 64'd0);
    endtask

    task automatic t_reset();
        chk("R1", 64'(cpu_ready), 64'd0);
        chk("R10", 64'(mem_req), 64'd0);
    endtask

    task automatic t_cold_miss();
        access(1'b0, mk(7'd1, 2'd1, 3'd3), 8'h00);
        chk("R1", 64'(rd_n), 64'd1);
        chk("R9", 64'(wr_n), 64'd0);
        chk("R1", 64'(got), 64'(pat({7'd1, 2'd1}, 3'd3)));
    endtask

    task automatic t_read_hit();
        access(1'b0, mk(7'd1, 2'd1, 3'd5), 8'h00);
        chk("R2", 64'(rd_n + wr_n), 64'd0);
        chk("R2", 64'(lat), 64'd2);
        chk("R2", 64'(got), 64'(pat({7'd1, 2'd1}, 3'd5)));
    endtask

    task automatic t_second_way();
        access(1'b0, mk(7'd2, 2'd1, 3'd0), 8'h00);
        chk("R5", 64'(rd_n), 64'd1);
        chk("R5", 64'(got), 64'(pat({7'd2, 2'd1}, 3'd0)));
        access(1'b0, mk(7'd1, 2'd1, 3'd1), 8'h00);
        chk("R3", 64'(rd_n + wr_n), 64'd0);
        chk("R3", 64'(got), 64'(pat({7'd1, 2'd1}, 3'd1)));
    endtask

    task automatic t_lru();
        access(1'b0, mk(7'd2, 2'd1, 3'd2), 8'h00);
        chk("R3", 64'(rd_n + wr_n), 64'd0);
        access(1'b0, mk(7'd1, 2'd1, 3'd2), 8'h00);
        access(1'b0, mk(7'd3, 2'd1, 3'd4), 8'h00);
        chk("R4", 64'(rd_n), 64'd1);
        chk("R9", 64'(wr_n), 64'd0);
        chk("R4", 64'(got), 64'(pat({7'd3, 2'd1}, 3'd4)));
        access(1'b0, mk(7'd1, 2'd1, 3'd6), 8'h00);
        chk("R4", 64'(rd_n + wr_n), 64'd0);
        access(1'b0, mk(7'd2, 2'd1, 3'd6), 8'h00);
        chk("R4", 64'(rd_n), 64'd1);
    endtask

    task automatic t_write_hit();
        access(1'b1, mk(7'd1, 2'd1, 3'd2), 8'hA5);
        chk("R6", 64'(rd_n + wr_n), 64'd0);
        access(1'b0, mk(7'd1, 2'd1, 3'd2), 8'h00);
        chk("R6", 64'(got), 64'hA5);
        chk("R6", 64'(mem[{7'd1, 2'd1}][23:16]), 64'(pat({7'd1, 2'd1}, 3'd2)));
    endtask

    task automatic t_writeback();
        access(1'b0, mk(7'd2, 2'd1, 3'd0), 8'h00);
        access(1'b0, mk(7'd4, 2'd1, 3'd1), 8'h00);
        chk("R8", 64'(wr_n), 64'd1);
        chk("R8", 64'(rd_n), 64'd1);
        chk("R8", 64'(first_we), 64'd1);
        chk("R8", 64'(wb_addr), 64'({7'd1, 2'd1}));
        chk("R8", 64'(mem[{7'd1, 2'd1}][23:16]), 64'hA5);
        chk("R8", 64'(mem[{7'd1, 2'd1}][63:56]), 64'(pat({7'd1, 2'd1}, 3'd7)));
        chk("R8", 64'(got), 64'(pat({7'd4, 2'd1}, 3'd1)));
    endtask

    task automatic t_write_miss();
        access(1'b1, mk(7'd5, 2'd2, 3'd7), 8'h3C);
        chk("R7", 64'(rd_n), 64'd1);
        chk("R7", 64'(wr_n), 64'd0);
        access(1'b0, mk(7'd5, 2'd2, 3'd7), 8'h00);
        chk("R7", 64'(rd_n + wr_n), 64'd0);
        chk("R7", 64'(got), 64'h3C);
        chk("R7", 64'(mem[{7'd5, 2'd2}][63:56]), 64'(pat({7'd5, 2'd2}, 3'd7)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_cold_miss();
        t_read_hit();
        t_second_way();
        t_lru();
        t_write_hit();
        t_writeback();
        t_write_miss();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule